// File: doc/BRIEF.md
# Ordered Write Buffer with Load Bypass

This block sits between one processor's memory port and memory and holds stores that have been accepted but not yet written. Loads never wait behind those stores. A load whose address matches a held store takes its data from the youngest such store. A load with no match reads memory in the same cycle. Writes go out one at a time on a valid/acknowledge channel.

A mode input chooses the drain discipline. With `mode_pso` low (total order), the oldest store always goes first and waits while its memory bank is busy. With `mode_pso` high (partial order), the oldest store whose bank is free goes first, so stores to idle banks can pass a blocked one. Stores to one address always stay in one bank, so they keep program order. Memory reports busy banks per bank, and the bank of an address is its low address bits.

A fence request holds off all new loads and stores. It reports completion once every buffered store has been written and acknowledged.

Top module: `wbuf_order_top`

## Requirements
- R1: After reset, `st_ready` and `ld_ready` are 1, and `mw_valid` and `fence_done` are 0 while `fence_req` is 0.
- R2: A store is taken in a cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 0 whenever DEPTH stores are buffered, which holds back a processor that finds the buffer full.
- R3: A load to an address that matches no buffered or in-flight store drives `mr_en`=1 with `mr_addr`=`ld_addr` and returns `mr_rdata` in the same cycle, even when older stores are still queued.
- R4: A load that matches a buffered or in-flight store returns the data of the youngest matching store in the same cycle, with `mr_en`=0. A store taken in the same cycle is not visible to that load.
- R5: With `mode_pso`=0, writes leave in the order the stores were accepted. The oldest store is issued only when `bank_busy[addr mod NBANK]` is 0.
- R6: With `mode_pso`=1, the next write is the oldest buffered store whose bank (`addr mod NBANK`) is not busy.
- R7: In both modes, stores to the same address are written in program order.
- R8: Only one write is outstanding. `mw_valid`, `mw_addr` and `mw_data` hold steady until `mw_ack`. A queued store is issued one cycle after it becomes eligible while the channel is free or being acknowledged.
- R9: While `fence_req` is 1, `st_ready`, `ld_ready` and `mr_en` are 0.
- R10: `fence_done` is 1 exactly when `fence_req` is 1, no store is buffered and no write awaits acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pso | input | 1 | 0: total store order, 1: partial store order |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load can proceed |
| ld_addr | input | AW | Load address |
| ld_rdata | output | DW | Load result, same cycle |
| mr_en | output | 1 | Memory read strobe |
| mr_addr | output | AW | Memory read address |
| mr_rdata | input | DW | Memory read data, combinational |
| fence_req | input | 1 | Fence request, held until done |
| fence_done | output | 1 | Fence complete |
| mw_valid | output | 1 | Memory write request |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| mw_ack | input | 1 | Memory write accepted |
| bank_busy | input | NBANK | Per-bank write busy |

## Verification
The bench builds the block with DEPTH=4, NBANK=4, AW=8 and DW=16. The shallow buffer makes the full stall happen within a few stores. The narrow address space puts several stores on one address and one bank, so forwarding among several same-address stores and reordering between banks both occur often under random traffic. A behavioural queue model runs alongside the block in both modes, through fences and across mode switches.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic {
        ORD_TOTAL   = 1'b0,
        ORD_PARTIAL = 1'b1
    } ord_mode_e;

    localparam int WB_AW_DEF    = 16;
    localparam int WB_DW_DEF    = 32;
    localparam int WB_DEPTH_DEF = 8;
    localparam int WB_NBANK_DEF = 4;

endpackage

// File: rtl/wbuf_pick.sv
module wbuf_pick
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NBANK = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH),
    localparam int BW = $clog2(NBANK)
) (
    input  ord_mode_e        mode,
    input  logic [BW-1:0]    ent_bank [DEPTH],
    input  logic [CW-1:0]    count,
    input  logic [NBANK-1:0] bank_busy,
    output logic             pick_ok,
    output logic [IW-1:0]    pick_idx
);

    logic [DEPTH-1:0] eligible;

    for (genvar g = 0; g < DEPTH; g++) begin : g_elig
        assign eligible[g] = (CW'(g) < count) && !bank_busy[ent_bank[g]];
    end

    always_comb begin
        pick_ok  = 1'b0;
        pick_idx = '0;
        if (mode == ORD_TOTAL) begin
            pick_ok = eligible[0];
        end else begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (eligible[i]) begin
                    pick_ok  = 1'b1;
                    pick_idx = IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0] ent_addr [DEPTH],
    input  logic [DW-1:0] ent_data [DEPTH],
    input  logic [CW-1:0] count,
    input  logic          out_v,
    input  logic [AW-1:0] out_a,
    input  logic [DW-1:0] out_d,
    input  logic [AW-1:0] ld_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        if (out_v && out_a == ld_addr) begin
            hit      = 1'b1;
            hit_data = out_d;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < count && ent_addr[i] == ld_addr) begin
                hit      = 1'b1;
                hit_data = ent_data[i];
            end
        end
    end

endmodule

// File: rtl/wbuf_order_top.sv
module wbuf_order_top
    import wbuf_pkg::*;
#(
    parameter int AW    = WB_AW_DEF,
    parameter int DW    = WB_DW_DEF,
    parameter int DEPTH = WB_DEPTH_DEF,
    parameter int NBANK = WB_NBANK_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_pso,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [AW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    input  logic             ld_valid,
    output logic             ld_ready,
    input  logic [AW-1:0]    ld_addr,
    output logic [DW-1:0]    ld_rdata,
    output logic             mr_en,
    output logic [AW-1:0]    mr_addr,
    input  logic [DW-1:0]    mr_rdata,
    input  logic             fence_req,
    output logic             fence_done,
    output logic             mw_valid,
    output logic [AW-1:0]    mw_addr,
    output logic [DW-1:0]    mw_data,
    input  logic             mw_ack,
    input  logic [NBANK-1:0] bank_busy
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);
    localparam int BW = $clog2(NBANK);

    logic [AW-1:0] ent_addr [DEPTH];
    logic [DW-1:0] ent_data [DEPTH];
    logic [AW-1:0] nxt_addr [DEPTH];
    logic [DW-1:0] nxt_data [DEPTH];
    logic [BW-1:0] ent_bank [DEPTH];
    logic [CW-1:0] count;
    logic [CW-1:0] base;

    logic          out_v;
    logic [AW-1:0] out_a;
    logic [DW-1:0] out_d;

    ord_mode_e     mode;
    logic          pick_ok;
    logic [IW-1:0] pick_idx;
    logic          fwd_hit;
    logic [DW-1:0] fwd_data;
    logic          push;
    logic          pop;

    assign mode = ord_mode_e'(mode_pso);

    for (genvar g = 0; g < DEPTH; g++) begin : g_bank
        assign ent_bank[g] = ent_addr[g][BW-1:0];
    end

    wbuf_pick #(.DEPTH(DEPTH), .NBANK(NBANK)) pick_i (
        .mode      (mode),
        .ent_bank  (ent_bank),
        .count     (count),
        .bank_busy (bank_busy),
        .pick_ok   (pick_ok),
        .pick_idx  (pick_idx)
    );

    wbuf_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) fwd_i (
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .count    (count),
        .out_v    (out_v),
        .out_a    (out_a),
        .out_d    (out_d),
        .ld_addr  (ld_addr),
        .hit      (fwd_hit),
        .hit_data (fwd_data)
    );

    // processor side
    assign st_ready   = (count < CW'(DEPTH)) && !fence_req;
    assign ld_ready   = !fence_req;
    assign push       = st_valid && st_ready;
    assign mr_en      = ld_valid && ld_ready && !fwd_hit;
    assign mr_addr    = ld_addr;
    assign ld_rdata   = fwd_hit ? fwd_data : mr_rdata;
    assign fence_done = fence_req && (count == '0) && !out_v;

    // memory write side
    assign pop      = pick_ok && (!out_v || mw_ack);
    assign mw_valid = out_v;
    assign mw_addr  = out_a;
    assign mw_data  = out_d;

    // compacting queue: entry 0 is oldest
    always_comb begin
        nxt_addr = ent_addr;
        nxt_data = ent_data;
        base     = count - CW'(pop);
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop && i >= int'(pick_idx)) begin
                nxt_addr[i] = ent_addr[i+1];
                nxt_data[i] = ent_data[i+1];
            end
        end
        if (push) begin
            nxt_addr[IW'(base)] = st_addr;
            nxt_data[IW'(base)] = st_data;
        end
    end

    always_ff @(posedge clk) begin
        ent_addr <= nxt_addr;
        ent_data <= nxt_data;
        if (rst) begin
            count <= '0;
            out_v <= 1'b0;
            out_a <= '0;
            out_d <= '0;
        end else begin
            count <= count + CW'(push) - CW'(pop);
            if (pop) begin
                out_v <= 1'b1;
                out_a <= ent_addr[pick_idx];
                out_d <= ent_data[pick_idx];
            end else if (mw_ack) begin
                out_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wbuf_order_chk.sv
module wbuf_order_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_pso,
    input logic [CW-1:0] count,
    input logic [AW-1:0] ent_addr [DEPTH],
    input logic          pop,
    input logic [IW-1:0] pick_idx,
    input logic          st_ready,
    input logic          ld_ready,
    input logic          mr_en,
    input logic          fwd_hit,
    input logic          fence_req,
    input logic          fence_done,
    input logic          mw_valid,
    input logic          mw_ack,
    input logic [AW-1:0] mw_addr,
    input logic [DW-1:0] mw_data
);

    logic older_same;

    always_comb begin
        older_same = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < count && i < int'(pick_idx) && ent_addr[i] == ent_addr[pick_idx])
                older_same = 1'b1;
        end
    end

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |-> !st_ready); // R2

    AST_FWD_SKIPS_READ: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> !mr_en); // R4

    AST_TOTAL_HEAD_ONLY: assert property (@(posedge clk) disable iff (rst)
        (pop && !mode_pso) |-> (pick_idx == '0)); // R5

    AST_SAME_ADDR_ORDER: assert property (@(posedge clk) disable iff (rst)
        pop |-> !older_same); // R7

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ack) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data))); // R8

    AST_FENCE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        fence_req |-> (!st_ready && !ld_ready && !mr_en)); // R9

    AST_FENCE_DONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        fence_done |-> (fence_req && count == '0 && !mw_valid)); // R10

endmodule

bind wbuf_order_top wbuf_order_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_pso   (mode_pso),
    .count      (count),
    .ent_addr   (ent_addr),
    .pop        (pop),
    .pick_idx   (pick_idx),
    .st_ready   (st_ready),
    .ld_ready   (ld_ready),
    .mr_en      (mr_en),
    .fwd_hit    (fwd_hit),
    .fence_req  (fence_req),
    .fence_done (fence_done),
    .mw_valid   (mw_valid),
    .mw_ack     (mw_ack),
    .mw_addr    (mw_addr),
    .mw_data    (mw_data)
);

// File: tb/wbuf_order_top_tb_top.sv
`timescale 1ns/1ps
module wbuf_order_top_tb_top;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int NBANK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_pso = 1'b0;
    logic st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic fence_req = 1'b0;
    logic mw_ack = 1'b0;
    logic [NBANK-1:0] bank_busy = '0;
    logic st_ready, ld_ready, mr_en, fence_done, mw_valid;
    logic [DW-1:0] ld_rdata, mw_data, mr_rdata;
    logic [AW-1:0] mr_addr, mw_addr;

    always #2 clk = ~clk;

    assign mr_rdata = {mr_addr, ~mr_addr};

    wbuf_order_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .NBANK(NBANK)) dut_i (
        .clk(clk), .rst(rst), .mode_pso(mode_pso),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_rdata(ld_rdata),
        .mr_en(mr_en), .mr_addr(mr_addr), .mr_rdata(mr_rdata),
        .fence_req(fence_req), .fence_done(fence_done),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack),
        .bank_busy(bank_busy)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // reference model
    logic [AW-1:0] qa[$];
    logic [DW-1:0] qd[$];
    int            qs[$];
    logic          m_ov = 1'b0;
    logic [AW-1:0] m_oa = '0;
    logic [DW-1:0] m_od = '0;
    int            m_os = 0;
    int            seq = 0;
    int            last_seq [int];
    logic          hold_prev = 1'b0;
    logic [AW+DW:0] prev_word = '0;
    logic          seen_done = 1'b0;
    int unsigned   rs = 32'h1234_5678;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic cyc();
        logic e_st, e_ld, e_mr, e_done, hit;
        logic [DW-1:0] hd;
        int idx;
        string wtag;
        #1;
        e_st = (qa.size() < DEPTH) && !fence_req;
        e_ld = !fence_req;
        hit = 1'b0;
        hd = '0;
        for (int j = qa.size() - 1; j >= 0; j--) begin
            if (!hit && qa[j] == ld_addr) begin
                hit = 1'b1;
                hd = qd[j];
            end
        end
        if (!hit && m_ov && m_oa == ld_addr) begin
            hit = 1'b1;
            hd = m_od;
        end
        if (!hit) hd = {ld_addr, ~ld_addr};
        e_mr = ld_valid && !fence_req && !hit;
        e_done = fence_req && qa.size() == 0 && !m_ov;
        chk(fence_req ? "R9" : "R2", 32'(st_ready), 32'(e_st));
        chk("R9", 32'(ld_ready), 32'(e_ld));
        chk(hit ? "R4" : "R3", 32'(mr_en), 32'(e_mr));
        if (ld_valid && !fence_req) chk(hit ? "R4" : "R3", 32'(ld_rdata), 32'(hd));
        chk("R10", 32'(fence_done), 32'(e_done));
        wtag = mode_pso ? "R6" : "R5";
        chk(wtag, 32'(mw_valid), 32'(m_ov));
        if (m_ov) begin
            chk(wtag, 32'(mw_addr), 32'(m_oa));
            chk(wtag, 32'(mw_data), 32'(m_od));
        end
        if (hold_prev) chk("R8", 32'({mw_valid, mw_addr, mw_data}), 32'(prev_word));
        hold_prev = mw_valid && !mw_ack;
        prev_word = {mw_valid, mw_addr, mw_data};
        seen_done = fence_done;
        // pick
        idx = -1;
        if (!mode_pso) begin
            if (qa.size() > 0 && !bank_busy[qa[0][1:0]]) idx = 0;
        end else begin
            for (int j = 0; j < qa.size(); j++)
                if (idx < 0 && !bank_busy[qa[j][1:0]]) idx = j;
        end
        @(posedge clk);
        if (m_ov && mw_ack) begin
            if (last_seq.exists(int'(m_oa)))
                chk("R7", 32'(m_os > last_seq[int'(m_oa)]), 32'd1);
            last_seq[int'(m_oa)] = m_os;
        end
        if (idx >= 0 && (!m_ov || mw_ack)) begin
            m_ov = 1'b1;
            m_oa = qa[idx];
            m_od = qd[idx];
            m_os = qs[idx];
            qa.delete(idx);
            qd.delete(idx);
            qs.delete(idx);
        end else if (mw_ack) begin
            m_ov = 1'b0;
        end
        if (st_valid && e_st) begin
            qa.push_back(st_addr);
            qd.push_back(st_data);
            qs.push_back(seq);
            seq++;
        end
        @(negedge clk);
    endtask

    task automatic drv(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input logic lv, input logic [AW-1:0] la, input logic ack,
                       input logic [NBANK-1:0] busy, input logic fen);
        st_valid = sv; st_addr = sa; st_data = sd;
        ld_valid = lv; ld_addr = la;
        mw_ack = ack; bank_busy = busy; fence_req = fen;
        cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle after reset
        chk("R1", 32'(st_ready), 32'd1);
        chk("R1", 32'(ld_ready), 32'd1);
        chk("R1", 32'(mw_valid), 32'd0);
        chk("R1", 32'(fence_done), 32'd0);
        @(negedge clk);

        // total order: head in busy bank 0 blocks, buffer fills (R2, R5)
        mode_pso = 1'b0;
        drv(1, 8'h10, 16'h0001, 0, 0, 0, 4'b0001, 0);
        drv(1, 8'h21, 16'h0002, 0, 0, 0, 4'b0001, 0);
        drv(1, 8'h22, 16'h0003, 1, 8'h10, 0, 4'b0001, 0);
        drv(1, 8'h21, 16'h0004, 1, 8'h21, 0, 4'b0001, 0);
        drv(1, 8'h33, 16'h0005, 1, 8'h21, 0, 4'b0001, 0); // full: refused (R2), youngest 21 (R4)
        drv(0, 0, 0, 1, 8'h40, 0, 4'b0001, 0);            // bypass miss (R3)
        for (int k = 0; k < 10; k++) drv(0, 0, 0, 1, 8'h21, 1, 4'b0000, 0);

        // partial order: bank 0 busy, later banks pass (R6, R7)
        mode_pso = 1'b1;
        drv(1, 8'h10, 16'h0011, 0, 0, 1, 4'b0001, 0);
        drv(1, 8'h11, 16'h0012, 0, 0, 1, 4'b0001, 0);
        drv(1, 8'h10, 16'h0013, 1, 8'h10, 1, 4'b0001, 0);
        drv(1, 8'h12, 16'h0014, 1, 8'h10, 0, 4'b0001, 0);
        drv(0, 0, 0, 1, 8'h10, 1, 4'b0001, 0);
        drv(0, 0, 0, 1, 8'h12, 1, 4'b0001, 0);
        for (int k = 0; k < 8; k++) drv(0, 0, 0, 1, 8'h10, 1, 4'b0000, 0);

        // fence: blocks, completes only after last ack (R9, R10)
        drv(1, 8'h05, 16'h0021, 0, 0, 0, 4'b0000, 0);
        drv(1, 8'h06, 16'h0022, 0, 0, 0, 4'b0000, 0);
        for (int k = 0; k < 4; k++) drv(1, 8'h07, 16'h0023, 1, 8'h05, 0, 4'b0000, 1);
        for (int k = 0; k < 6; k++) drv(0, 0, 0, 1, 8'h06, 1, 4'b0000, 1);
        drv(0, 0, 0, 1, 8'h06, 1, 4'b0000, 0);

        // mixed traffic
        for (int k = 0; k < 4000; k++) begin
            int unsigned r1, r2;
            logic fen;
            r1 = rnd();
            r2 = rnd();
            if (k % 500 == 0) mode_pso = ~mode_pso;
            fen = fence_req ? !seen_done : (r2[31:26] == 6'd0);
            drv(r1[0], {4'h0, r1[4:1]}, r1[31:16], r1[5], {4'h0, r1[9:6]},
                r1[10] | r1[11], r2[3:0] & r2[7:4], fen);
        end
        for (int k = 0; k < 20; k++) drv(0, 0, 0, 0, 0, 1, 4'b0000, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule